// File: doc/BRIEF.md
# Two-Bit Subset Enumerator

The block walks through every way of picking two of the set bits of a mask word and presents one such pick per step as a word with exactly two bits high. The order is fixed. Bit position 1 is the leftmost bit, which is index `W-1` of the vector. The left member of a pair stays where it is while the right member moves rightward over the set mask bits. When the right member has no set mask bit left to move onto, the left member moves to the next set mask bit toward the right, and the right member restarts on the set mask bit just after it.

A `startPulse` captures the mask and shows the leftmost pair. Each `stepPulse` moves to the following pair in a single clock. Once the list is used up, the block reports completion. A separate combinational port answers "what follows this pair?" for the live mask. The sequencer uses a second copy of the same next-pair logic, fed from its held mask and current pair.

Top module: `pair_enum`

## Requirements
- R1: When `qryErr` is low, `qryNext` has exactly two bits set, and both are bits that are set in `maskIn`.
- R2: On the query port, if a set mask bit exists to the right of the pair's right member, the left member is kept and the right member moves to the nearest such bit (e.g. mask 10101111, pair 10100000 gives 10001000).
- R3: On the query port, if the right member is on the rightmost set mask bit, the left member moves to the nearest set mask bit to its right, and the right member goes to the nearest set mask bit to the right of that (e.g. mask 10101111, pair 10000001 gives 00101000; mask 10001110, pair 00001010 gives 00000110).
- R4: `qryErr` is high and `qryNext` is zero when `maskIn` has fewer than two set bits, when `qryCombo` does not have exactly two set bits, or when a bit of `qryCombo` is clear in `maskIn`.
- R5: `qryErr` is high and `qryNext` is zero when the given pair is the last one (e.g. mask 10101111, pair 00000011).
- R6: A `startPulse` in a mask with at least two set bits loads, one clock later, the two leftmost set mask bits into `comboOut`. `validOut` is then high and `doneOut` and `errOut` are low.
- R7: A `startPulse` in a mask with fewer than two set bits gives, one clock later, `errOut` high, `validOut` low and `comboOut` zero.
- R8: While `validOut` is high, each `stepPulse` moves `comboOut` to the next pair in one clock. The sequence uses the mask captured at start, so changes on `maskIn` afterwards have no effect on it.
- R9: A `stepPulse` on the last pair gives `doneOut` high, `validOut` low and `comboOut` zero. This state holds through further steps until the next start.
- R10: A synchronous active-high `rst` clears `validOut`, `doneOut`, `errOut` and `comboOut` one clock later.
- R11: A `stepPulse` while `validOut` is low changes nothing. When start and step arrive in the same cycle, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| maskIn | input | W | Mask word; captured on start, used live by the query port |
| startPulse | input | 1 | Capture the mask and show the first pair |
| stepPulse | input | 1 | Advance to the next pair |
| comboOut | output | W | Current pair, zero when not valid |
| validOut | output | 1 | `comboOut` holds a pair |
| doneOut | output | 1 | All pairs have been shown |
| errOut | output | 1 | Captured mask had fewer than two set bits |
| qryCombo | input | W | Pair to be advanced on the query port |
| qryNext | output | W | Pair that follows `qryCombo` under `maskIn` |
| qryErr | output | 1 | No valid successor for `qryCombo` |

## Verification
The bench builds the block with its default width of eight. At that width all 256 masks can be started and walked through to completion, and each walk is compared pair by pair against a nested-loop enumeration. The walks therefore cover masks with zero, one, two and eight set bits, adjacent and widely spaced set bits, and the move onto the done state. A scrambled `maskIn` is applied during every walk to show that the held mask is the one in use. The query vectors exercise the malformed-pair and exhausted cases on top of ordinary advances.

// File: rtl/pair_enum_pkg.sv
package pair_enum_pkg;

  typedef struct packed {
    logic load;
    logic fail;
    logic advance;
    logic finish;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE,
    ST_ERR
  } seqState_t;

endpackage

// File: rtl/pair_next_logic.sv
module pair_next_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] maskIn,
  input  logic [W-1:0] comboIn,
  output logic [W-1:0] nextOut,
  output logic         errOut
);

  // Index of the highest set bit of v strictly below lim, or -1 if there is none.
  function automatic int highestBelow(input logic [W-1:0] v, input int lim);
    int r;
    r = -1;
    for (int i = 0; i < W; i++) begin
      if (v[i] && (i < lim)) r = i;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] oneHot(input int p);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i == p);
    return r;
  endfunction

  int  hiPos, loPos, rightPos, leftPos, pairPos;
  logic shapeBad;

  always_comb begin
    hiPos    = highestBelow(comboIn, W);
    loPos    = highestBelow(comboIn, hiPos);
    rightPos = highestBelow(maskIn, loPos);
    leftPos  = highestBelow(maskIn, hiPos);
    pairPos  = highestBelow(maskIn, leftPos);
    shapeBad = ($countones(comboIn) != 2) || (|(comboIn & ~maskIn)) ||
               ($countones(maskIn) < 2);
    nextOut  = '0;
    errOut   = 1'b0;
    if (shapeBad) begin
      errOut = 1'b1;
    end else if (rightPos >= 0) begin
      nextOut = oneHot(hiPos) | oneHot(rightPos);
    end else if (pairPos >= 0) begin
      nextOut = oneHot(leftPos) | oneHot(pairPos);
    end else begin
      errOut = 1'b1;
    end
  end

endmodule

// File: rtl/pair_enum_ctrl.sv
module pair_enum_ctrl
  import pair_enum_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         startPulse,
  input  logic         stepPulse,
  input  logic         firstOk,
  input  logic         nextErr,
  output ctrlStrobes_t strobes,
  output logic         validOut,
  output logic         doneOut,
  output logic         errOut
);

  seqState_t state, stateNxt;

  always_comb begin
    strobes  = '0;
    stateNxt = state;
    if (startPulse) begin
      if (firstOk) begin
        strobes.load = 1'b1;
        stateNxt     = ST_RUN;
      end else begin
        strobes.fail = 1'b1;
        stateNxt     = ST_ERR;
      end
    end else if (stepPulse && (state == ST_RUN)) begin
      if (nextErr) begin
        strobes.finish = 1'b1;
        stateNxt       = ST_DONE;
      end else begin
        strobes.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  assign validOut = (state == ST_RUN);
  assign doneOut  = (state == ST_DONE);
  assign errOut   = (state == ST_ERR);

endmodule

// File: rtl/pair_enum_dp.sv
module pair_enum_dp
  import pair_enum_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] maskIn,
  input  ctrlStrobes_t strobes,
  output logic         firstOk,
  output logic         nextErr,
  output logic [W-1:0] heldMask,
  output logic [W-1:0] comboOut
);

  logic [W-1:0] topBit, secBit, firstCombo, seqNext;

  // Two leftmost set bits of the incoming mask.
  always_comb begin
    topBit = '0;
    secBit = '0;
    for (int i = 0; i < W; i++) begin
      if (maskIn[i]) begin
        secBit    = topBit;
        topBit    = '0;
        topBit[i] = 1'b1;
      end
    end
    firstCombo = topBit | secBit;
    firstOk    = |secBit;
  end

  pair_next_logic #(.W(W)) u_seqNext (
    .maskIn  (heldMask),
    .comboIn (comboOut),
    .nextOut (seqNext),
    .errOut  (nextErr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      heldMask <= '0;
      comboOut <= '0;
    end else if (strobes.load) begin
      heldMask <= maskIn;
      comboOut <= firstCombo;
    end else if (strobes.fail) begin
      heldMask <= maskIn;
      comboOut <= '0;
    end else if (strobes.advance) begin
      comboOut <= seqNext;
    end else if (strobes.finish) begin
      comboOut <= '0;
    end
  end

endmodule

// File: rtl/pair_enum.sv
module pair_enum
  import pair_enum_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] maskIn,
  input  logic         startPulse,
  input  logic         stepPulse,
  output logic [W-1:0] comboOut,
  output logic         validOut,
  output logic         doneOut,
  output logic         errOut,
  input  logic [W-1:0] qryCombo,
  output logic [W-1:0] qryNext,
  output logic         qryErr
);

  ctrlStrobes_t strobes;
  logic         firstOk;
  logic         nextErr;
  logic [W-1:0] heldMask;

  pair_enum_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .stepPulse  (stepPulse),
    .firstOk    (firstOk),
    .nextErr    (nextErr),
    .strobes    (strobes),
    .validOut   (validOut),
    .doneOut    (doneOut),
    .errOut     (errOut)
  );

  pair_enum_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .maskIn   (maskIn),
    .strobes  (strobes),
    .firstOk  (firstOk),
    .nextErr  (nextErr),
    .heldMask (heldMask),
    .comboOut (comboOut)
  );

  pair_next_logic #(.W(W)) u_qryNext (
    .maskIn  (maskIn),
    .comboIn (qryCombo),
    .nextOut (qryNext),
    .errOut  (qryErr)
  );

endmodule

// File: rtl/pair_enum_checker.sv
module pair_enum_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         startPulse,
  input logic         stepPulse,
  input logic [W-1:0] maskIn,
  input logic [W-1:0] heldMask,
  input logic [W-1:0] comboOut,
  input logic         validOut,
  input logic         doneOut,
  input logic         errOut,
  input logic [W-1:0] qryNext,
  input logic         qryErr
);

  p_qry_pair_r1: assert property (@(posedge clk) disable iff (rst)
    !qryErr |-> ($countones(qryNext) == 2) && ((qryNext & ~maskIn) == '0));

  p_qry_err_zero_r4: assert property (@(posedge clk) disable iff (rst)
    qryErr |-> (qryNext == '0));

  p_seq_pair_r6: assert property (@(posedge clk) disable iff (rst)
    validOut |-> ($countones(comboOut) == 2) && ((comboOut & ~heldMask) == '0));

  p_flags_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({validOut, doneOut, errOut}) && (!validOut -> (comboOut == '0)));

  p_order_r8: assert property (@(posedge clk) disable iff (rst)
    (validOut && stepPulse && !startPulse) |=>
      ((validOut && (comboOut < $past(comboOut))) || doneOut));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (doneOut && !startPulse) |=> (doneOut && (comboOut == '0)));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!validOut && !doneOut && !errOut && (comboOut == '0)));

  p_idle_step_r11: assert property (@(posedge clk) disable iff (rst)
    (!validOut && stepPulse && !startPulse) |=>
      ($stable(comboOut) && $stable(validOut) && $stable(doneOut) && $stable(errOut)));

endmodule

bind pair_enum pair_enum_checker #(.W(W)) u_checker (.*);

// File: tb/test_pair_enum.sv
module test_pair_enum;

  localparam int BW = 8;
  localparam int NQ = 13;
  // {mask, pair, expected successor, expected error}
  localparam logic [3*BW:0] QTAB [NQ] = '{
    {8'b10101111, 8'b10100000, 8'b10001000, 1'b0},
    {8'b10101111, 8'b10001000, 8'b10000100, 1'b0},
    {8'b10101111, 8'b10000010, 8'b10000001, 1'b0},
    {8'b10101111, 8'b10000001, 8'b00101000, 1'b0},
    {8'b10101111, 8'b00101000, 8'b00100100, 1'b0},
    {8'b10101111, 8'b00100100, 8'b00100010, 1'b0},
    {8'b10001110, 8'b00001010, 8'b00000110, 1'b0},
    {8'b11111111, 8'b11000000, 8'b10100000, 1'b0},
    {8'b10101111, 8'b00000011, 8'b00000000, 1'b1},
    {8'b11001110, 8'b00000110, 8'b00000000, 1'b1},
    {8'b00010000, 8'b00010000, 8'b00000000, 1'b1},
    {8'b10101111, 8'b10100001, 8'b00000000, 1'b1},
    {8'b10101111, 8'b01000001, 8'b00000000, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BW-1:0] maskIn = '0;
  logic startPulse = 1'b0;
  logic stepPulse = 1'b0;
  logic [BW-1:0] qryCombo = '0;
  logic [BW-1:0] comboOut, qryNext;
  logic validOut, doneOut, errOut, qryErr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pair_enum #(.W(BW)) i_pair_enum (
    .clk(clk), .rst(rst), .maskIn(maskIn), .startPulse(startPulse),
    .stepPulse(stepPulse), .comboOut(comboOut), .validOut(validOut),
    .doneOut(doneOut), .errOut(errOut), .qryCombo(qryCombo),
    .qryNext(qryNext), .qryErr(qryErr)
  );

  task automatic chkState(input string tag, input logic v, input logic d,
                          input logic e, input logic [BW-1:0] c);
    checks++;
    if ({validOut, doneOut, errOut, comboOut} !== {v, d, e, c}) begin
      failures++;
      $display("FAIL %s: v/d/e/combo actual %b%b%b %b expected %b%b%b %b",
               tag, validOut, doneOut, errOut, comboOut, v, d, e, c);
    end
  endtask

  task automatic pulse(input logic s, input logic t);
    startPulse = s;
    stepPulse  = t;
    @(negedge clk);
    startPulse = 1'b0;
    stepPulse  = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chkState("R10 reset", 1'b0, 1'b0, 1'b0, '0);
    rst = 1'b0;

    // Query port vectors.
    for (int k = 0; k < NQ; k++) begin
      maskIn   = QTAB[k][3*BW:2*BW+1];
      qryCombo = QTAB[k][2*BW:BW+1];
      #1;
      checks++;
      if ({qryErr, qryNext} !== {QTAB[k][0], QTAB[k][BW:1]}) begin
        failures++;
        $display("FAIL %s vector %0d: err/next actual %b %b expected %b %b",
                 QTAB[k][0] ? "R4_R5" : "R1_R2_R3", k, qryErr, qryNext,
                 QTAB[k][0], QTAB[k][BW:1]);
      end
    end
    @(negedge clk);

    // Step while idle is ignored.
    pulse(1'b0, 1'b1);
    chkState("R11 idle step", 1'b0, 1'b0, 1'b0, '0);

    // Start and step together: start wins.
    maskIn = 8'hFF;
    pulse(1'b1, 1'b1);
    chkState("R11 start priority", 1'b1, 1'b0, 1'b0, 8'b11000000);
    pulse(1'b0, 1'b1);
    chkState("R2 step", 1'b1, 1'b0, 1'b0, 8'b10100000);

    // Reset in the middle of a walk.
    rst = 1'b1;
    @(negedge clk);
    chkState("R10 mid-run reset", 1'b0, 1'b0, 1'b0, '0);
    rst = 1'b0;

    // Full walks over every mask, with the live mask scrambled after start.
    for (int m = 0; m < 256; m++) begin
      logic [BW-1:0] mv;
      bit firstPair;
      mv = BW'(m);
      maskIn = mv;
      pulse(1'b1, 1'b0);
      maskIn = ~mv;
      if ($countones(mv) < 2) begin
        chkState("R7 short mask", 1'b0, 1'b0, 1'b1, '0);
        pulse(1'b0, 1'b1);
        chkState("R11 step in error", 1'b0, 1'b0, 1'b1, '0);
      end else begin
        firstPair = 1'b1;
        for (int i = BW - 1; i > 0; i--) begin
          for (int j = i - 1; j >= 0; j--) begin
            if (mv[i] && mv[j]) begin
              logic [BW-1:0] exp;
              exp = '0;
              exp[i] = 1'b1;
              exp[j] = 1'b1;
              if (firstPair) begin
                chkState("R6 first pair", 1'b1, 1'b0, 1'b0, exp);
              end else begin
                pulse(1'b0, 1'b1);
                chkState("R8 next pair", 1'b1, 1'b0, 1'b0, exp);
              end
              firstPair = 1'b0;
            end
          end
        end
        pulse(1'b0, 1'b1);
        chkState("R9 exhausted", 1'b0, 1'b1, 1'b0, '0);
        pulse(1'b0, 1'b1);
        chkState("R9 done holds", 1'b0, 1'b1, 1'b0, '0);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule